// File: doc/BRIEF.md
# Flash Command and Interrupt Controller

This block is the register-mapped front end of a NAND-style flash device. Software writes a command code into a command register. The controller sorts the code into a class: load, program, erase, erase resume, housekeeping, reset, no-op or unknown. It then either completes the command at once or hands it to the array back end and waits for that back end to report success or failure. Completion and error results are collected in an interrupt status register and a controller status register.

An interrupt pin follows the master interrupt bit, with a polarity chosen by the configuration register. A ready pin follows a configuration bit each time that register is written. While the master interrupt bit is set, and while an array operation is still outstanding, new commands are dropped. Software acknowledges a result by writing a mask to the interrupt register; once the master bit is clear, the error flags are cleared as well.

The array back end sits outside the block. The controller pulses `op_start` with the code on `op_code`. The back end answers some cycles later with a one-cycle `op_done`, and with `op_fail` held high during that same cycle if the operation failed.

Top module: `fcic_top`

Register map (`reg_addr`): 0 = command (the code is in bits 7:0), 1 = configuration, 2 = controller status (read only), 3 = interrupt status. Status bits: 10 command error, 11 erase error, 12 program error, 13 load error. Interrupt bits: 4 reset done, 5 erase, 6 program, 7 load, 15 master. Configuration bits: 6 interrupt polarity, 7 ready.

## Requirements
- R1: After cold reset the interrupt register reads 0x8080, the status register reads 0, the configuration register reads 0x40C0, the command register reads 0, and both `irq_o` and `rdy_o` are 1.
- R2: A command write is dropped while interrupt bit 15 is set: the command register keeps its value, no array operation starts, and the interrupt and status registers do not change.
- R3: A write to the interrupt register leaves the bitwise AND of the written value and the old contents.
- R4: When an interrupt register write leaves bit 15 clear, status bits 13:10 are cleared. If bit 15 stays set, those bits are kept.
- R5: `irq_o` equals interrupt bit 15 XOR the inverse of configuration bit 6.
- R6: A read of the configuration register returns the stored value with bits 4:0 forced to 0. A write to it sets `rdy_o` to the written bit 7.
- R7: Load codes 0x00 and 0x13 start an array operation. One cycle after `op_done` is sampled, interrupt bits 15 and 7 are set. On failure, status bits 10 and 13 are also set.
- R8: Program codes 0x80, 0x1A and 0x1B start an array operation. On completion they set interrupt bits 15 and 6. On failure they also set status bits 10 and 12.
- R9: Erase codes 0x94 and 0x95 start an array operation. On completion they set interrupt bits 15 and 5. On failure they also set status bits 10 and 11. Erase resume 0x30 sets interrupt bits 15 and 5 at once and starts no array operation.
- R10: Any code the controller does not recognise sets status bit 10 and interrupt bit 15. Codes 0x23, 0x27, 0x2A, 0x2C, 0x65 and 0x71 set only interrupt bit 15. Code 0xB0 sets nothing. None of these start an array operation.
- R11: Codes 0xF0 and 0xF3, and a pulse on `warm_rst`, return the block to its warm defaults: interrupt 0x8010, status 0, configuration 0x40C0, command 0, `rdy_o` 1.
- R12: A command write is dropped while an array operation is outstanding.
- R13: When a hardware completion and an interrupt register write land in the same cycle, the bits set by hardware win over the bits cleared by the write, in both the interrupt and the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst | input | 1 | Synchronous warm reset pulse |
| reg_addr | input | ADDR_W | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Interrupt pin |
| rdy_o | output | 1 | Ready pin |
| op_start | output | 1 | One-cycle start pulse to the array back end |
| op_code | output | CODE_W | Code of the started operation |
| op_done | input | 1 | One-cycle completion strobe from the back end |
| op_fail | input | 1 | Failure flag, valid with op_done |

## Verification
Each command class is tried against a back end that succeeds and against one that fails, and with different response delays. This separates the interrupt bits of each class from the error bits of each class, and shows the result is timed from the strobe rather than from the issue. Command writes are aimed at the block while the master bit is set and while an operation is outstanding, which tells the interrupt gate and the busy gate apart. Acknowledge masks that keep bit 15 set are contrasted with masks that clear it, and one acknowledge is placed in the exact cycle of a completion to expose the merge priority. Polarity and ready writes are checked on both pin values.

// File: rtl/fcic_pkg.sv
package fcic_pkg;

   typedef enum logic [2:0] {
      CLS_NONE,
      CLS_LOAD,
      CLS_PROG,
      CLS_ERASE,
      CLS_RESUME,
      CLS_PLAIN,
      CLS_RESET,
      CLS_BAD
   } cmd_cls_e;

   localparam int REG_W = 16;

   // status register error flags
   localparam int ST_ERR_CMD   = 10;
   localparam int ST_ERR_ERASE = 11;
   localparam int ST_ERR_PROG  = 12;
   localparam int ST_ERR_LOAD  = 13;

   // interrupt register bits
   localparam int IS_RESET  = 4;
   localparam int IS_ERASE  = 5;
   localparam int IS_PROG   = 6;
   localparam int IS_LOAD   = 7;
   localparam int IS_MASTER = 15;

   // configuration bits
   localparam int CFG_POL = 6;
   localparam int CFG_RDY = 7;

   localparam logic [REG_W-1:0] CFG_DEFAULT = 16'h40C0;
   localparam logic [REG_W-1:0] CFG_RD_MASK = 16'hFFE0;
   localparam logic [REG_W-1:0] IS_COLD     = 16'h8080;
   localparam logic [REG_W-1:0] IS_WARM     = 16'h8010;
   localparam logic [REG_W-1:0] ERR_MASK    = 16'h3C00;

endpackage

// File: rtl/fcic_decode.sv
module fcic_decode
   import fcic_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic [CODE_W-1:0] code,
   output cmd_cls_e          cls
);

   generate
      if (CODE_W != 8) begin : g_bad_code_w
         $error("fcic_decode: CODE_W must be 8");
      end
   endgenerate

   always_comb begin
      unique case (code)
         8'h00, 8'h13:                          cls = CLS_LOAD;
         8'h80, 8'h1A, 8'h1B:                   cls = CLS_PROG;
         8'h94, 8'h95:                          cls = CLS_ERASE;
         8'h30:                                 cls = CLS_RESUME;
         8'h23, 8'h27, 8'h2A, 8'h2C,
         8'h65, 8'h71:                          cls = CLS_PLAIN;
         8'hB0:                                 cls = CLS_NONE;
         8'hF0, 8'hF3:                          cls = CLS_RESET;
         default:                               cls = CLS_BAD;
      endcase
   end

endmodule

// File: rtl/fcic_seq.sv
module fcic_seq
   import fcic_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              issue,
   input  cmd_cls_e          issue_cls,
   input  logic [CODE_W-1:0] issue_code,
   input  logic              op_done,
   input  logic              op_fail,
   output logic              op_start,
   output logic [CODE_W-1:0] op_code,
   output logic              busy,
   output logic              fin,
   output logic              fin_fail,
   output cmd_cls_e          fin_cls
);

   cmd_cls_e cls_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_start <= 1'b0;
         op_code  <= '0;
         busy     <= 1'b0;
         fin      <= 1'b0;
         fin_fail <= 1'b0;
         cls_q    <= CLS_NONE;
      end else if (flush) begin
         op_start <= 1'b0;
         busy     <= 1'b0;
         fin      <= 1'b0;
         fin_fail <= 1'b0;
      end else begin
         op_start <= issue;
         if (issue) begin
            busy    <= 1'b1;
            op_code <= issue_code;
            cls_q   <= issue_cls;
         end else if (fin) begin
            busy    <= 1'b0;
         end
         fin      <= busy && !fin && op_done;
         fin_fail <= op_fail;
      end
   end

   assign fin_cls = cls_q;

   // R7: a strobe seen while busy is reported on the next cycle
   a_r7_strobe_to_fin: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin && op_done && !flush) |=> fin);

endmodule

// File: rtl/fcic_regs.sv
module fcic_regs
   import fcic_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             warm,
   input  logic             cfg_we,
   input  logic             int_we,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] hw_int_set,
   input  logic [REG_W-1:0] hw_err_set,
   output logic [REG_W-1:0] cfg,
   output logic [REG_W-1:0] stat,
   output logic [REG_W-1:0] ist,
   output logic             rdy
);

   generate
      if (DATA_W < REG_W) begin : g_bad_data_w
         $error("fcic_regs: DATA_W must be at least 16");
      end
   endgenerate

   logic [REG_W-1:0] ist_masked, ist_nx, stat_nx;
   logic             wipe;

   always_comb begin
      ist_masked = int_we ? (ist & wdata) : ist;
      ist_nx     = ist_masked | hw_int_set;
      wipe       = int_we && !ist_nx[IS_MASTER];
      stat_nx    = (wipe ? (stat & ~ERR_MASK) : stat) | hw_err_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= CFG_DEFAULT;
         stat <= '0;
         ist  <= IS_COLD;
         rdy  <= 1'b1;
      end else if (warm) begin
         cfg  <= CFG_DEFAULT;
         stat <= '0;
         ist  <= IS_WARM;
         rdy  <= 1'b1;
      end else begin
         ist  <= ist_nx;
         stat <= stat_nx;
         if (cfg_we) begin
            cfg <= wdata;
            rdy <= wdata[CFG_RDY];
         end
      end
   end

   // R3: nothing survives an acknowledge unless written as 1 or set by hardware
   a_r3_and_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (int_we && !warm) |=> ((ist & ~$past(wdata | hw_int_set)) == '0));

   // R4: errors are gone once the master bit is acknowledged away
   a_r4_err_wipe: assert property (@(posedge clk) disable iff (!rst_n)
      (int_we && !warm && !wdata[IS_MASTER] && !hw_int_set[IS_MASTER]
       && hw_err_set == '0) |=> ((stat & ERR_MASK) == '0));

   // R6: the ready pin takes the written bit 7
   a_r6_rdy_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !warm) |=> (rdy == $past(wdata[CFG_RDY])));

endmodule

// File: rtl/fcic_top.sv
module fcic_top
   import fcic_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 2,
   parameter int CODE_W   = 8,
   parameter bit IRQ_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              warm_rst,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o,
   output logic              rdy_o,
   output logic              op_start,
   output logic [CODE_W-1:0] op_code,
   input  logic              op_done,
   input  logic              op_fail
);

   localparam logic [ADDR_W-1:0] ADR_CMD  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] ADR_CFG  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] ADR_INT  = ADDR_W'(3);

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("fcic_top: ADDR_W must be at least 2");
      end
      if (DATA_W < REG_W) begin : g_bad_data_w
         $error("fcic_top: DATA_W must be at least 16");
      end
   endgenerate

   logic [REG_W-1:0]  cfg, stat, ist;
   logic [REG_W-1:0]  wdata16;
   logic [CODE_W-1:0] code_in, cmd_q;
   cmd_cls_e          cls_in, fin_cls;
   logic              cmd_we, cfg_we, int_we, accept, issue, warm_all;
   logic              busy, fin, fin_fail;
   logic [REG_W-1:0]  imm_int, imm_err, fin_int, fin_err;

   assign wdata16 = reg_wdata[REG_W-1:0];
   assign code_in = reg_wdata[CODE_W-1:0];
   assign cmd_we  = reg_we && (reg_addr == ADR_CMD);
   assign cfg_we  = reg_we && (reg_addr == ADR_CFG);
   assign int_we  = reg_we && (reg_addr == ADR_INT);

   fcic_decode #(.CODE_W(CODE_W)) u_decode (
      .code (code_in),
      .cls  (cls_in)
   );

   assign accept   = cmd_we && !ist[IS_MASTER] && !busy;
   assign warm_all = warm_rst || (accept && cls_in == CLS_RESET);
   assign issue    = accept && (cls_in == CLS_LOAD || cls_in == CLS_PROG ||
                                cls_in == CLS_ERASE);

   // results that are known in the cycle the command is accepted
   always_comb begin
      imm_int = '0;
      imm_err = '0;
      if (accept) begin
         unique case (cls_in)
            CLS_RESUME: begin
               imm_int[IS_MASTER] = 1'b1;
               imm_int[IS_ERASE]  = 1'b1;
            end
            CLS_PLAIN:  imm_int[IS_MASTER] = 1'b1;
            CLS_BAD: begin
               imm_int[IS_MASTER]  = 1'b1;
               imm_err[ST_ERR_CMD] = 1'b1;
            end
            default: ;
         endcase
      end
   end

   // results reported by the array back end
   always_comb begin
      fin_int = '0;
      fin_err = '0;
      if (fin) begin
         fin_int[IS_MASTER]  = 1'b1;
         fin_err[ST_ERR_CMD] = fin_fail;
         unique case (fin_cls)
            CLS_LOAD: begin
               fin_int[IS_LOAD]     = 1'b1;
               fin_err[ST_ERR_LOAD] = fin_fail;
            end
            CLS_PROG: begin
               fin_int[IS_PROG]     = 1'b1;
               fin_err[ST_ERR_PROG] = fin_fail;
            end
            CLS_ERASE: begin
               fin_int[IS_ERASE]     = 1'b1;
               fin_err[ST_ERR_ERASE] = fin_fail;
            end
            default: ;
         endcase
      end
   end

   fcic_seq #(.CODE_W(CODE_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (warm_all),
      .issue      (issue),
      .issue_cls  (cls_in),
      .issue_code (code_in),
      .op_done    (op_done),
      .op_fail    (op_fail),
      .op_start   (op_start),
      .op_code    (op_code),
      .busy       (busy),
      .fin        (fin),
      .fin_fail   (fin_fail),
      .fin_cls    (fin_cls)
   );

   fcic_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .warm       (warm_all),
      .cfg_we     (cfg_we),
      .int_we     (int_we),
      .wdata      (wdata16),
      .hw_int_set (imm_int | fin_int),
      .hw_err_set (imm_err | fin_err),
      .cfg        (cfg),
      .stat       (stat),
      .ist        (ist),
      .rdy        (rdy_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (warm_all) begin
         cmd_q <= '0;
      end else if (accept) begin
         cmd_q <= code_in;
      end
   end

   always_comb begin
      unique case (reg_addr)
         ADR_CMD:  reg_rdata = DATA_W'(cmd_q);
         ADR_CFG:  reg_rdata = DATA_W'(cfg & CFG_RD_MASK);
         ADR_STAT: reg_rdata = DATA_W'(stat);
         ADR_INT:  reg_rdata = DATA_W'(ist);
         default:  reg_rdata = '0;
      endcase
   end

   generate
      if (IRQ_FLOP) begin : g_irq_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o <= 1'b1;
            else        irq_o <= ist[IS_MASTER] ^ ~cfg[CFG_POL];
         end
         // R5: registered pin follows the previous cycle's bits
         a_r5_irq_flop: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o == ($past(ist[IS_MASTER]) ^ ~$past(cfg[CFG_POL]))));
      end else begin : g_irq_comb
         assign irq_o = ist[IS_MASTER] ^ ~cfg[CFG_POL];
      end
   endgenerate

   // R2: gated command writes change nothing downstream
   a_r2_gate_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && ist[IS_MASTER] && !warm_rst) |=> ($stable(cmd_q) && !op_start));

   // R12: no second start while an operation is outstanding
   a_r12_gate_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && busy && !warm_rst) |=> ($stable(cmd_q) && !op_start));

   // R7: completion raises the master bit
   a_r7_fin_master: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !warm_rst) |=> ist[IS_MASTER]);

   // R7: a failed completion raises the command error flag
   a_r7_fin_error: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && fin_fail && !warm_rst) |=> stat[ST_ERR_CMD]);

   // R11: warm reset pin yields warm defaults
   a_r11_warm_pin: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst |=> (ist == IS_WARM && stat == '0 && rdy_o));

endmodule

// File: tb/fcic_top_bench.sv
module fcic_top_bench;

   localparam int DATA_W = 16;
   localparam int ADDR_W = 2;
   localparam int CODE_W = 8;

   localparam int A_CMD = 0, A_CFG = 1, A_ST = 2, A_INT = 3;
   localparam int K_REG = 0, K_IRQ = 1, K_RDY = 2, K_STARTS = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              warm_rst = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic              reg_we = 1'b0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              irq_o, rdy_o, op_start;
   logic [CODE_W-1:0] op_code;
   logic              op_done = 1'b0;
   logic              op_fail = 1'b0;

   int checks = 0;
   int errors = 0;
   int starts = 0;
   int stub_delay = 2;
   bit stub_fail = 1'b0;
   bit done_flag = 1'b0;

   typedef struct {
      int          kind;
      int          addr;
      logic [15:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];

   always #4 clk = ~clk;

   fcic_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_fcic_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .warm_rst  (warm_rst),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_o     (irq_o),
      .rdy_o     (rdy_o),
      .op_start  (op_start),
      .op_code   (op_code),
      .op_done   (op_done),
      .op_fail   (op_fail)
   );

   // start-pulse counter, sampled after the edge has settled
   always @(posedge clk) begin
      #2;
      if (op_start === 1'b1) starts++;
   end

   // behavioural array stub
   always begin
      @(negedge clk);
      if (op_start === 1'b1) begin
         repeat (stub_delay) @(posedge clk);
         #1;
         op_done = 1'b1;
         op_fail = stub_fail;
         @(posedge clk);
         #1;
         op_done = 1'b0;
         op_fail = 1'b0;
      end
   end

   // monitor: pops expectations and compares against the outputs
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         logic [15:0] act;
         it = sb_q.pop_front();
         case (it.kind)
            K_REG:   act = reg_rdata[15:0];
            K_IRQ:   act = {15'd0, irq_o};
            K_RDY:   act = {15'd0, rdy_o};
            default: act = 16'(starts);
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s kind %0d addr %0d actual 0x%04h expected 0x%04h",
                     it.tag, it.kind, it.addr, act, it.exp);
         end
      end
   end

   task automatic expect_item(input int kind, input int addr, input logic [15:0] exp,
                              input string tag);
      item_t it;
      @(posedge clk);
      #1;
      reg_we   = 1'b0;
      reg_addr = ADDR_W'(addr);
      it.kind = kind;
      it.addr = addr;
      it.exp  = exp;
      it.tag  = tag;
      sb_q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input int addr, input logic [15:0] data);
      @(posedge clk);
      #1;
      reg_addr  = ADDR_W'(addr);
      reg_wdata = data;
      reg_we    = 1'b1;
      @(posedge clk);
      #1;
      reg_we    = 1'b0;
   endtask

   task automatic settle();
      repeat (stub_delay + 6) @(posedge clk);
   endtask

   task automatic run_cmd(input logic [7:0] code, input int dly, input bit fail);
      stub_delay = dly;
      stub_fail  = fail;
      wr(A_CMD, {8'h00, code});
      settle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int s0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: cold reset state
      expect_item(K_REG, A_INT, 16'h8080, "R1 int");
      expect_item(K_REG, A_ST,  16'h0000, "R1 status");
      expect_item(K_REG, A_CFG, 16'h40C0, "R1 cfg");
      expect_item(K_REG, A_CMD, 16'h0000, "R1 cmd");
      expect_item(K_IRQ, 0, 16'h1, "R1 irq");
      expect_item(K_RDY, 0, 16'h1, "R1 rdy");

      // R2: command ignored while master bit set
      run_cmd(8'h00, 2, 1'b0);
      expect_item(K_REG, A_CMD, 16'h0000, "R2 cmd kept");
      expect_item(K_STARTS, 0, 16'd0, "R2 no start");
      expect_item(K_REG, A_INT, 16'h8080, "R2 int kept");

      // R3: AND semantics
      wr(A_INT, 16'hFF7F);
      expect_item(K_REG, A_INT, 16'h8000, "R3 and mask");
      wr(A_INT, 16'h0000);
      expect_item(K_REG, A_INT, 16'h0000, "R3 all clear");
      expect_item(K_IRQ, 0, 16'h0, "R5 irq low pol1");

      // R5/R6: polarity and ready
      wr(A_CFG, 16'h0000);
      expect_item(K_IRQ, 0, 16'h1, "R5 irq inverted");
      expect_item(K_RDY, 0, 16'h0, "R6 rdy low");
      wr(A_CFG, 16'h40DF);
      expect_item(K_REG, A_CFG, 16'h40C0, "R6 cfg read mask");
      expect_item(K_RDY, 0, 16'h1, "R6 rdy high");
      expect_item(K_IRQ, 0, 16'h0, "R5 irq normal");

      // R7: load success
      run_cmd(8'h00, 3, 1'b0);
      expect_item(K_REG, A_INT, 16'h8080, "R7 load int");
      expect_item(K_REG, A_ST,  16'h0000, "R7 load ok status");
      expect_item(K_STARTS, 0, 16'd1, "R7 one start");
      expect_item(K_IRQ, 0, 16'h1, "R5 irq on done");
      run_cmd(8'h80, 1, 1'b0);
      expect_item(K_REG, A_CMD, 16'h0000, "R2 cmd kept after load");
      expect_item(K_STARTS, 0, 16'd1, "R2 no second start");
      wr(A_INT, 16'h7FFF);
      expect_item(K_REG, A_INT, 16'h0080, "R3 keep load bit");

      // R7: load fail, R4 keep then wipe
      run_cmd(8'h13, 1, 1'b1);
      expect_item(K_REG, A_INT, 16'h8080, "R7 load fail int");
      expect_item(K_REG, A_ST,  16'h2400, "R7 load fail status");
      wr(A_INT, 16'hFFFF);
      expect_item(K_REG, A_ST,  16'h2400, "R4 errors kept");
      wr(A_INT, 16'h0000);
      expect_item(K_REG, A_ST,  16'h0000, "R4 errors wiped");

      // R8: program
      run_cmd(8'h1A, 2, 1'b1);
      expect_item(K_REG, A_INT, 16'h8040, "R8 prog fail int");
      expect_item(K_REG, A_ST,  16'h1400, "R8 prog fail status");
      wr(A_INT, 16'h0000);
      run_cmd(8'h1B, 4, 1'b0);
      expect_item(K_REG, A_INT, 16'h8040, "R8 copy prog int");
      expect_item(K_REG, A_ST,  16'h0000, "R8 prog ok status");
      wr(A_INT, 16'h0000);

      // R12: busy gate
      s0 = starts;
      stub_delay = 12;
      stub_fail  = 1'b0;
      wr(A_CMD, 16'h0080);
      wr(A_CMD, 16'h0094);
      settle();
      expect_item(K_REG, A_CMD, 16'h0080, "R12 cmd kept");
      expect_item(K_STARTS, 0, 16'(s0 + 1), "R12 one start");
      expect_item(K_REG, A_INT, 16'h8040, "R12 prog result");
      wr(A_INT, 16'h0000);

      // R9: erase
      run_cmd(8'h95, 2, 1'b1);
      expect_item(K_REG, A_INT, 16'h8020, "R9 erase fail int");
      expect_item(K_REG, A_ST,  16'h0C00, "R9 erase fail status");
      wr(A_INT, 16'h0000);
      s0 = starts;
      run_cmd(8'h30, 2, 1'b0);
      expect_item(K_REG, A_INT, 16'h8020, "R9 resume int");
      expect_item(K_STARTS, 0, 16'(s0), "R9 resume no start");
      wr(A_INT, 16'h0000);

      // R10: unknown, housekeeping, no-op
      run_cmd(8'h42, 2, 1'b0);
      expect_item(K_REG, A_ST,  16'h0400, "R10 bad status");
      expect_item(K_REG, A_INT, 16'h8000, "R10 bad int");
      wr(A_INT, 16'h0000);
      run_cmd(8'h2C, 2, 1'b0);
      expect_item(K_REG, A_INT, 16'h8000, "R10 plain int");
      expect_item(K_REG, A_ST,  16'h0000, "R10 plain status");
      wr(A_INT, 16'h0000);
      run_cmd(8'hB0, 2, 1'b0);
      expect_item(K_REG, A_INT, 16'h0000, "R10 noop int");
      expect_item(K_REG, A_CMD, 16'h00B0, "R10 noop cmd");
      expect_item(K_STARTS, 0, 16'(s0), "R10 no starts");

      // R13: hardware set wins over same-cycle clear
      stub_delay = 2;
      stub_fail  = 1'b1;
      wr(A_CMD, 16'h0000);
      @(posedge clk iff op_done === 1'b1);
      #1;
      reg_addr  = ADDR_W'(A_INT);
      reg_wdata = 16'h0000;
      reg_we    = 1'b1;
      @(posedge clk);
      #1;
      reg_we    = 1'b0;
      expect_item(K_REG, A_INT, 16'h8080, "R13 int set wins");
      expect_item(K_REG, A_ST,  16'h2400, "R13 status set wins");
      wr(A_INT, 16'h0000);

      // R11: reset commands and warm pin
      wr(A_CFG, 16'h0000);
      run_cmd(8'hF0, 2, 1'b0);
      expect_item(K_REG, A_INT, 16'h8010, "R11 F0 int");
      expect_item(K_REG, A_CFG, 16'h40C0, "R11 F0 cfg");
      expect_item(K_REG, A_CMD, 16'h0000, "R11 F0 cmd");
      expect_item(K_RDY, 0, 16'h1, "R11 F0 rdy");
      wr(A_INT, 16'h0000);
      wr(A_CFG, 16'h0000);
      run_cmd(8'hF3, 2, 1'b0);
      expect_item(K_REG, A_INT, 16'h8010, "R11 F3 int");
      expect_item(K_RDY, 0, 16'h1, "R11 F3 rdy");
      wr(A_INT, 16'h0000);
      wr(A_CFG, 16'h0000);
      run_cmd(8'h42, 2, 1'b0);
      @(posedge clk);
      #1 warm_rst = 1'b1;
      @(posedge clk);
      #1 warm_rst = 1'b0;
      expect_item(K_REG, A_INT, 16'h8010, "R11 pin int");
      expect_item(K_REG, A_ST,  16'h0000, "R11 pin status");
      expect_item(K_REG, A_CFG, 16'h40C0, "R11 pin cfg");
      expect_item(K_RDY, 0, 16'h1, "R11 pin rdy");

      repeat (3) @(posedge clk);
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule